// File: doc/BRIEF.md
# Core Stall and Hand-off Sequencer

This block sequences a single-issue, in-order core through its run, idle and cache-miss stall conditions. It decides each cycle whether the core may advance (`tick_en_o`). It tells the fetch stage when the instruction already held must be executed without fetching it again (`skip_fetch_o`). It pulses a late-execute strobe when a load that stalled on the data cache finally gets its data.

The block also manages the core's hand-off to another core. A hand-off request made while a data-cache miss is still outstanding is held back until that miss completes. In every other state the core is released at once and the hand-off is acknowledged. Two saturating counters gather the number of cycles spent stalled on each cache. A statistics-clear input zeroes both counters.

Decode, execute, translation and the caches lie outside the block. The block sees the caches only through miss strobes, a read/write flag for the missing data access, and a completion pulse.

Top module: `core_stall_seq`

## Requirements
- R1: After reset `state_o` is Idle, and every output including both counters and `err_o` is zero. The state codes on `state_o` are: Idle 0, Running 1, fetch-miss stall 2, fetch-miss done 3, data-miss stall 4, data-miss with pending hand-off 5, handed-off 6.
- R2: `activate_i` moves Idle to Running, and `suspend_i` moves Running to Idle. Either request has no effect in any other state. In Running the priority is hand-off, then suspend, then fetch miss, then data miss.
- R3: `imiss_i` in Running enters the fetch-miss stall, and `tick_en_o` drops in the following cycle.
- R4: `miss_done_i` in the fetch-miss stall enters fetch-miss done. It also adds to `istall_cnt_o` the number of cycles the state spent as fetch-miss stall, counting the completion cycle.
- R5: In fetch-miss done, `tick_en_o` and `skip_fetch_o` are both 1 for exactly one cycle. The state then becomes Running. `tick_en_o` is 1 only in Running and fetch-miss done.
- R6: `dmiss_i` in Running enters the data-miss stall and captures `dmiss_rd_i` (1 means read). On `miss_done_i` the state returns to Running and `dstall_cnt_o` grows by the stalled cycles. `late_exec_o` pulses for one cycle only if the captured access was a read.
- R7: `switch_req_i` in the data-miss stall enters the pending hand-off state. `miss_done_i` there gives the late-execute pulse for a read, enters handed-off and pulses `switch_ack_o`, without adding to `dstall_cnt_o`. Completion and hand-off arriving in the same cycle in the data-miss stall do both at once: the counter is updated, the late pulse is given for a read, and the acknowledge is pulsed.
- R8: `switch_req_i` in Idle, Running, fetch-miss stall or fetch-miss done enters handed-off in one cycle, pulses `switch_ack_o` and holds `tick_en_o` low.
- R9: In handed-off, `miss_done_i` and all requests are ignored. Only reset leaves the state.
- R10: `miss_done_i` in Idle, Running or fetch-miss done sets `err_o`, which stays set until reset. The state is unchanged.
- R11: Both stall counters saturate at all ones instead of wrapping.
- R12: `stat_clr_i` zeroes both stall counters at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| activate_i | input | 1 | start the core from Idle |
| suspend_i | input | 1 | suspend, halt or release request |
| imiss_i | input | 1 | instruction fetch missed this cycle |
| dmiss_i | input | 1 | data access missed this cycle |
| dmiss_rd_i | input | 1 | missing data access is a read |
| miss_done_i | input | 1 | outstanding miss has completed |
| switch_req_i | input | 1 | hand core off to another core |
| stat_clr_i | input | 1 | clear stall counters |
| tick_en_o | output | 1 | core may advance this cycle |
| skip_fetch_o | output | 1 | execute held instruction, no refetch |
| late_exec_o | output | 1 | execute the stalled load now |
| switch_ack_o | output | 1 | hand-off complete |
| state_o | output | 3 | current state code |
| err_o | output | 1 | sticky: completion with nothing outstanding |
| istall_cnt_o | output | CNT_W | fetch stall cycles |
| dstall_cnt_o | output | CNT_W | data stall cycles |

## Verification
The state, the late-execute and acknowledge pulses, the error flag and the counters are all registered, so each result is due at the first rising edge after the stimulus is applied. `tick_en_o` and `skip_fetch_o` follow the new state in the same cycle. The bench applies inputs on the falling edge and samples one time unit after the next rising edge. Every expected value therefore belongs to the one edge that consumed the stimulus, and a pulse seen a cycle late or early counts as a mismatch.

// File: rtl/core_stall_seq.sv
module core_stall_seq #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate_i,
  input  logic             suspend_i,
  input  logic             imiss_i,
  input  logic             dmiss_i,
  input  logic             dmiss_rd_i,
  input  logic             miss_done_i,
  input  logic             switch_req_i,
  input  logic             stat_clr_i,
  output logic             tick_en_o,
  output logic             skip_fetch_o,
  output logic             late_exec_o,
  output logic             switch_ack_o,
  output logic [2:0]       state_o,
  output logic             err_o,
  output logic [CNT_W-1:0] istall_cnt_o,
  output logic [CNT_W-1:0] dstall_cnt_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_IMISS = 3'd2, S_IDONE = 3'd3,
                         S_DMISS = 3'd4, S_DSW = 3'd5, S_OUT = 3'd6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       st, st_n;
  logic             rd_q, rd_n, err_n, late_n, ack_n, iadd, dadd;
  logic [CNT_W-1:0] tmr, elapsed;
  logic [CNT_W:0]   isum, dsum, tinc;

  assign tick_en_o    = (st == S_RUN) || (st == S_IDONE);
  assign skip_fetch_o = (st == S_IDONE);
  assign state_o      = st;

  assign tinc    = {1'b0, tmr} + 1'b1;
  assign elapsed = tinc[CNT_W] ? CNT_MAX : tinc[CNT_W-1:0];
  assign isum    = {1'b0, istall_cnt_o} + {1'b0, elapsed};
  assign dsum    = {1'b0, dstall_cnt_o} + {1'b0, elapsed};

  always_comb begin
    st_n   = st;
    rd_n   = rd_q;
    err_n  = err_o;
    late_n = 1'b0;
    ack_n  = 1'b0;
    iadd   = 1'b0;
    dadd   = 1'b0;
    case (st)
      S_IDLE: begin
        if (switch_req_i) begin
          st_n = S_OUT; ack_n = 1'b1;
        end else if (activate_i) st_n = S_RUN;
        if (miss_done_i) err_n = 1'b1;
      end
      S_RUN: begin
        if (switch_req_i) begin
          st_n = S_OUT; ack_n = 1'b1;
        end else if (suspend_i) st_n = S_IDLE;
        else if (imiss_i) st_n = S_IMISS;
        else if (dmiss_i) begin
          st_n = S_DMISS; rd_n = dmiss_rd_i;
        end
        if (miss_done_i) err_n = 1'b1;
      end
      S_IMISS: begin
        if (switch_req_i) begin
          st_n = S_OUT; ack_n = 1'b1;
        end else if (miss_done_i) begin
          st_n = S_IDONE; iadd = 1'b1;
        end
      end
      S_IDONE: begin
        if (switch_req_i) begin
          st_n = S_OUT; ack_n = 1'b1;
        end else st_n = S_RUN;
        if (miss_done_i) err_n = 1'b1;
      end
      S_DMISS: begin
        if (miss_done_i) begin
          late_n = rd_q;
          dadd   = 1'b1;
          if (switch_req_i) begin
            st_n = S_OUT; ack_n = 1'b1;
          end else st_n = S_RUN;
        end else if (switch_req_i) st_n = S_DSW;
      end
      S_DSW: begin
        if (miss_done_i) begin
          late_n = rd_q; st_n = S_OUT; ack_n = 1'b1;
        end
      end
      default: st_n = S_OUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      rd_q         <= 1'b0;
      err_o        <= 1'b0;
      late_exec_o  <= 1'b0;
      switch_ack_o <= 1'b0;
      tmr          <= '0;
      istall_cnt_o <= '0;
      dstall_cnt_o <= '0;
    end else begin
      st           <= st_n;
      rd_q         <= rd_n;
      err_o        <= err_n;
      late_exec_o  <= late_n;
      switch_ack_o <= ack_n;
      tmr          <= (st == S_IMISS || st == S_DMISS) ? elapsed : '0;
      if (stat_clr_i) begin
        istall_cnt_o <= '0;
        dstall_cnt_o <= '0;
      end else begin
        if (iadd) istall_cnt_o <= isum[CNT_W] ? CNT_MAX : isum[CNT_W-1:0];
        if (dadd) dstall_cnt_o <= dsum[CNT_W] ? CNT_MAX : dsum[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/core_stall_seq_chk.sv
module core_stall_seq_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             imiss_i,
  input logic             suspend_i,
  input logic             miss_done_i,
  input logic             switch_req_i,
  input logic             stat_clr_i,
  input logic             tick_en_o,
  input logic             late_exec_o,
  input logic             switch_ack_o,
  input logic [2:0]       state_o,
  input logic             err_o,
  input logic [CNT_W-1:0] istall_cnt_o,
  input logic [CNT_W-1:0] dstall_cnt_o
);
  assert_fetch_miss_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && imiss_i && !switch_req_i && !suspend_i) |=> (state_o == 3'd2 && !tick_en_o));

  assert_done_resumes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd3 && !switch_req_i) |=> (state_o == 3'd1));

  assert_late_only_after_dmiss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    late_exec_o |-> ($past(state_o) == 3'd4 || $past(state_o) == 3'd5));

  assert_deferred_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd5 && miss_done_i) |=> (state_o == 3'd6 && switch_ack_o));

  assert_ack_in_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    switch_ack_o |-> (state_o == 3'd6 && !tick_en_o));

  assert_out_is_final_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd6) |=> (state_o == 3'd6));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_no_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr_i |=> (istall_cnt_o >= $past(istall_cnt_o) && dstall_cnt_o >= $past(dstall_cnt_o)));

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_i |=> (istall_cnt_o == '0 && dstall_cnt_o == '0));
endmodule

bind core_stall_seq core_stall_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .imiss_i(imiss_i), .suspend_i(suspend_i),
  .miss_done_i(miss_done_i), .switch_req_i(switch_req_i), .stat_clr_i(stat_clr_i),
  .tick_en_o(tick_en_o), .late_exec_o(late_exec_o), .switch_ack_o(switch_ack_o),
  .state_o(state_o), .err_o(err_o), .istall_cnt_o(istall_cnt_o), .dstall_cnt_o(dstall_cnt_o)
);

// File: tb/core_stall_seq_bench.sv
`timescale 1ns/100ps
module core_stall_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic act, sus, imiss, dmiss, rd, done, sw, clr;
  logic tick, skip, late, ack, err, tick_s, skip_s, late_s, ack_s, err_s;
  logic [2:0] st, st_s;
  logic [31:0] icnt, dcnt;
  logic [3:0] icnt_s, dcnt_s;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  core_stall_seq u_core_stall_seq (
    .clk(clk), .rst_n(rst_n), .activate_i(act), .suspend_i(sus), .imiss_i(imiss),
    .dmiss_i(dmiss), .dmiss_rd_i(rd), .miss_done_i(done), .switch_req_i(sw),
    .stat_clr_i(clr), .tick_en_o(tick), .skip_fetch_o(skip), .late_exec_o(late),
    .switch_ack_o(ack), .state_o(st), .err_o(err), .istall_cnt_o(icnt), .dstall_cnt_o(dcnt));

  core_stall_seq #(.CNT_W(4)) u_sat (
    .clk(clk), .rst_n(rst_n), .activate_i(act), .suspend_i(sus), .imiss_i(imiss),
    .dmiss_i(dmiss), .dmiss_rd_i(rd), .miss_done_i(done), .switch_req_i(sw),
    .stat_clr_i(clr), .tick_en_o(tick_s), .skip_fetch_o(skip_s), .late_exec_o(late_s),
    .switch_ack_o(ack_s), .state_o(st_s), .err_o(err_s), .istall_cnt_o(icnt_s), .dstall_cnt_o(dcnt_s));

  // {act,sus,imiss,dmiss,rd,done,sw}, expected state, late, ack
  localparam int NV = 15;
  localparam logic [11:0] VEC [NV] = '{
    12'b1000000_001_0_0, // R2 activate
    12'b0010000_010_0_0, // R3 fetch miss
    12'b0000000_010_0_0,
    12'b0000010_011_0_0, // R4 completion
    12'b0000000_001_0_0, // R5 resume
    12'b0001100_100_0_0, // R6 read miss
    12'b0000010_001_1_0, // R6 late strobe
    12'b0001000_100_0_0, // R6 write miss
    12'b0000000_100_0_0,
    12'b0000010_001_0_0, // R6 no strobe on write
    12'b0001100_100_0_0,
    12'b0000001_101_0_0, // R7 deferred hand-off
    12'b0000000_101_0_0,
    12'b0000010_110_1_1, // R7 complete then hand off
    12'b0000010_110_0_0  // R9 ignored
  };

  task automatic check(input string r, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic cyc(input logic [6:0] v, input logic c = 1'b0);
    @(negedge clk);
    {act, sus, imiss, dmiss, rd, done, sw} = v;
    clr = c;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {act, sus, imiss, dmiss, rd, done, sw, clr} = '0;
    @(posedge clk); @(posedge clk);
    #1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check("R1 state", st, 0);
    check("R1 outputs", {tick, skip, late, ack, err}, 0);
    check("R1 counters", icnt | dcnt, 0);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] es;
      cyc(VEC[i][11:5]);
      es = VEC[i][4:2];
      check($sformatf("R2 R3 R4 R6 R7 R9 state vec%0d", i), st, es);
      check($sformatf("R6 R7 late vec%0d", i), late, VEC[i][1]);
      check($sformatf("R7 R8 ack vec%0d", i), ack, VEC[i][0]);
      check($sformatf("R5 tick vec%0d", i), tick, (es == 3'd1 || es == 3'd3));
      check($sformatf("R5 skip vec%0d", i), skip, (es == 3'd3));
    end
    check("R4 istall", icnt, 2);
    check("R6 R7 dstall", dcnt, 3);
    check("R10 no error", err, 0);

    do_reset();
    cyc(7'b0100000);
    check("R2 suspend in Idle ignored", st, 0);
    cyc(7'b0000010);
    check("R10 err set", err, 1);
    check("R10 state kept", st, 0);
    cyc(7'b1000000);
    cyc(7'b0100000);
    check("R2 suspend to Idle", st, 0);
    check("R10 err sticky", err, 1);
    cyc(7'b1000000);
    cyc(7'b0000001);
    check("R8 immediate hand-off", st, 6);
    check("R8 ack", ack, 1);
    check("R8 tick low", tick, 0);
    cyc(7'b1000000);
    check("R9 activate ignored", st, 6);
    check("R8 ack one cycle", ack, 0);

    do_reset();
    cyc(7'b1000000);
    cyc(7'b0001100);
    cyc(7'b0000011);
    check("R7 same-cycle state", st, 6);
    check("R7 same-cycle late", late, 1);
    check("R7 same-cycle ack", ack, 1);
    check("R7 same-cycle dstall", dcnt, 1);

    do_reset();
    cyc(7'b1000000);
    cyc(7'b0010000);
    for (int k = 0; k < 20; k++) cyc(7'b0000000);
    cyc(7'b0000010);
    check("R4 long stall", icnt, 21);
    check("R11 saturate", icnt_s, 15);
    cyc(7'b0000000, 1'b1);
    check("R12 clear main", icnt, 0);
    check("R12 clear narrow", icnt_s, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule